// File: doc/BRIEF.md
# Timekeeper Control and Status Register Pair

This block holds the configuration and status state of a real-time timekeeping device: a 7-bit oscillator trim register and two 8-bit control/status registers. Software writes them over a simple strobed bus (address, data, write strobe), and their current contents are always visible on three readback outputs. The block also turns selected bits into live controls: the enables of the two interrupt outputs, the threshold select and the run/suspend state of the low-voltage monitor, and the gating of a free-running 32 kHz clock onto an output pin.

Two status flags are sticky. One records that the crystal oscillator has stopped; the other records that the supply has dropped below the monitor threshold. Each is set by a one-cycle pulse from a detector outside this block and is cleared only when software writes a 0 to its bit position. Writing a 1 leaves it as it is. An oscillator-stop event is honoured only while the host chip enable is low. It sets its flag and wipes every other bit of all three registers in the same cycle, so a device that lost its clock comes back with interrupts silenced and the 32 kHz output running. The 32 kHz output can be turned off only when a bit in each of the two control registers is set. A single runaway write therefore cannot silence it.

Top module: `tk_ctl_status`

## Requirements
- R1: After reset, trim_rd reads 0x00, cfga_rd reads 0x00 and cfgb_rd reads 0x10 (only the oscillator-stop flag, bit 4, is set).
- R2: A write strobe to address 7, 14 or 15 loads the trim, control A or control B register, visible on the readback from the next clock cycle. Writes to any other address change nothing.
- R3: A trim write whose data bit 7 is 1 is rejected and leaves the trim register unchanged. trim_rd bit 7 always reads 0 and bits 6:0 hold the last accepted value.
- R4: halt_evt while chip_en is low sets cfgb_rd bit 4 and clears every other bit of all three registers, the low-voltage flag included, in the next cycle. It wins over a write in the same cycle.
- R5: halt_evt while chip_en is high has no effect.
- R6: The oscillator-stop flag (cfgb bit 4) stays set until a write to address 15 carries 0 in bit 4. A 1 in that bit leaves the flag unchanged, whether set or clear.
- R7: lowv_evt sets the low-voltage flag (cfgb bit 6), which then holds. A write to address 15 with 0 in bit 6 clears it and a 1 leaves it unchanged. lowv_mon_en is the inverse of the flag.
- R8: lowv_evt is ignored while the low-voltage flag is set. A clearing write in the same cycle as such a pulse leaves the flag clear.
- R9: clk32_out follows clk32_in unless both cfga bit 4 and cfgb bit 3 are 1, in which case it is held high.
- R10: irq_b_en equals cfga bit 7. irq_a_en is 1 when cfga bit 6 is set or the periodic-tick select field cfga bits 2:0 is non-zero.
- R11: lowv_thr_low equals cfgb bit 7 (1 selects the lower monitor threshold). cfgb bits 5, 3, 2, 1 and 0 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | 8 | Write data |
| halt_evt | input | 1 | Oscillator-stop detector pulse |
| lowv_evt | input | 1 | Low-supply detector pulse |
| chip_en | input | 1 | Host chip-enable level; halt events count only while low |
| clk32_in | input | 1 | Free-running 32 kHz clock |
| trim_rd | output | 8 | Trim register readback, bit 7 always 0 |
| cfga_rd | output | 8 | Control register A readback |
| cfgb_rd | output | 8 | Control register B readback including both sticky flags |
| clk32_out | output | 1 | Gated 32 kHz clock, high when disabled |
| lowv_mon_en | output | 1 | Low-voltage monitor running |
| lowv_thr_low | output | 1 | Low-voltage monitor uses the lower threshold |
| irq_a_en | output | 1 | Enable for interrupt output A (periodic tick and day alarm) |
| irq_b_en | output | 1 | Enable for interrupt output B (weekday alarm) |

## Verification
The bench goes after the collisions. A halt arrives in the same cycle as a control write: a design that let the write win would come back from a clock loss with interrupts armed. A low-voltage pulse arrives while the flag is already set, together with a clearing write: a design that re-armed on that pulse would leave the flag stuck. Writes of 1 to either sticky bit must neither set nor clear it, and a trim write with bit 7 set must be rejected whole rather than truncated. The clock gate is driven with each enable bit alone and with both together, so a gate built with the wrong logic sense would silence the 32 kHz output with a single bit.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int DW     = 8;
    localparam int B_VDET = 6;
    localparam int B_XSTP = 4;

    // control register A, MSB first
    typedef struct packed {
        logic       walarm_en;
        logic       dalarm_en;
        logic       hr24;
        logic       clkoff_a;
        logic       test;
        logic [2:0] tick_sel;
    } cfg_a_t;

    // control register B, MSB first
    typedef struct packed {
        logic thr_low;
        logic lowv_seen;
        logic spare;
        logic halt_seen;
        logic clkoff_b;
        logic tick_flag;
        logic walarm_flag;
        logic dalarm_flag;
    } cfg_b_t;

endpackage

// File: rtl/tk_w0c_flag.sv
module tk_w0c_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    // set has priority over a clearing write
    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= RST_VAL;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/tk_clk32_gate.sv
module tk_clk32_gate (
    input  logic off_a,
    input  logic off_b,
    input  logic clk_in,
    output logic clk_out
);

    logic both_off;

    always_comb begin
        both_off = off_a & off_b;
        clk_out  = clk_in | both_off;
    end

endmodule

// File: rtl/tk_irq_enable.sv
module tk_irq_enable
    import tk_pkg::*;
(
    input  cfg_a_t cfg_a,
    output logic   irq_a_en,
    output logic   irq_b_en
);

    always_comb begin
        irq_a_en = cfg_a.dalarm_en | (|cfg_a.tick_sel);
        irq_b_en = cfg_a.walarm_en;
    end

endmodule

// File: rtl/tk_ctl_status.sv
module tk_ctl_status
    import tk_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int TRIM_W    = 7,
    parameter int TRIM_ADDR = 7,
    parameter int CFGA_ADDR = 14,
    parameter int CFGB_ADDR = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              halt_evt,
    input  logic              lowv_evt,
    input  logic              chip_en,
    input  logic              clk32_in,
    output logic [DW-1:0]     trim_rd,
    output logic [DW-1:0]     cfga_rd,
    output logic [DW-1:0]     cfgb_rd,
    output logic              clk32_out,
    output logic              lowv_mon_en,
    output logic              lowv_thr_low,
    output logic              irq_a_en,
    output logic              irq_b_en
);

    localparam int                PAD_W  = DW - TRIM_W;
    localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(TRIM_ADDR);
    localparam logic [ADDR_W-1:0] A_CFGA = ADDR_W'(CFGA_ADDR);
    localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(CFGB_ADDR);

    typedef struct packed {
        logic [TRIM_W-1:0] trim;
        cfg_a_t            a;
        cfg_b_t            b;
    } regs_t;

    regs_t regs_d, regs_q;

    logic wr_trim, wr_cfga, wr_cfgb;
    logic halt_hit;
    logic vdet, xstp;
    cfg_b_t rd_b;

    always_comb begin
        wr_trim  = wr_en && (wr_addr == A_TRIM) && !wr_data[DW-1];
        wr_cfga  = wr_en && (wr_addr == A_CFGA);
        wr_cfgb  = wr_en && (wr_addr == A_CFGB);
        halt_hit = halt_evt && !chip_en;
    end

    // plain storage next state; sticky flags live in their own cells
    always_comb begin
        regs_d = regs_q;
        if (wr_trim) regs_d.trim = wr_data[TRIM_W-1:0];
        if (wr_cfga) regs_d.a    = cfg_a_t'(wr_data);
        if (wr_cfgb) regs_d.b    = cfg_b_t'(wr_data);
        regs_d.b.lowv_seen = 1'b0;
        regs_d.b.halt_seen = 1'b0;
        if (halt_hit) regs_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tk_w0c_flag #(.RST_VAL(1'b1)) u_xstp (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (halt_hit),
        .clr_i  (wr_cfgb && !wr_data[B_XSTP]),
        .flag_o (xstp)
    );

    tk_w0c_flag #(.RST_VAL(1'b0)) u_vdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (lowv_evt && !vdet && !halt_hit),
        .clr_i  ((wr_cfgb && !wr_data[B_VDET]) || halt_hit),
        .flag_o (vdet)
    );

    always_comb begin
        rd_b           = regs_q.b;
        rd_b.lowv_seen = vdet;
        rd_b.halt_seen = xstp;
    end

    assign trim_rd      = {{PAD_W{1'b0}}, regs_q.trim};
    assign cfga_rd      = regs_q.a;
    assign cfgb_rd      = rd_b;
    assign lowv_mon_en  = ~vdet;
    assign lowv_thr_low = regs_q.b.thr_low;

    tk_clk32_gate u_gate (
        .off_a   (regs_q.a.clkoff_a),
        .off_b   (regs_q.b.clkoff_b),
        .clk_in  (clk32_in),
        .clk_out (clk32_out)
    );

    tk_irq_enable u_irq (
        .cfg_a    (regs_q.a),
        .irq_a_en (irq_a_en),
        .irq_b_en (irq_b_en)
    );

endmodule

// File: rtl/tk_ctl_status_chk.sv
module tk_ctl_status_chk #(
    parameter int ADDR_W    = 4,
    parameter int TRIM_ADDR = 7,
    parameter int CFGB_ADDR = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              halt_evt,
    input logic              lowv_evt,
    input logic              chip_en,
    input logic [7:0]        trim_rd,
    input logic [7:0]        cfga_rd,
    input logic [7:0]        cfgb_rd,
    input logic              clk32_out
);

    localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(TRIM_ADDR);
    localparam logic [ADDR_W-1:0] A_CFGB = ADDR_W'(CFGB_ADDR);

    logic hit;
    logic clr_x, clr_v;
    assign hit   = halt_evt && !chip_en;
    assign clr_x = wr_en && wr_addr == A_CFGB && !wr_data[4];
    assign clr_v = wr_en && wr_addr == A_CFGB && !wr_data[6];

    p_halt_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfgb_rd == 8'h10 && cfga_rd == 8'h00 && trim_rd == 8'h00));

    p_halt_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_evt && chip_en && !wr_en && !lowv_evt) |=>
        ($stable(cfga_rd) && $stable(cfgb_rd) && $stable(trim_rd)));

    p_trim_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TRIM && wr_data[7] && !hit) |=> $stable(trim_rd));

    p_xstp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfgb_rd[4] && !clr_x) |=> cfgb_rd[4]);

    p_vdet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfgb_rd[6] && !clr_v && !hit) |=> cfgb_rd[6]);

    p_vdet_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfgb_rd[6] && clr_v) |=> !cfgb_rd[6]);

    p_clk_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfga_rd[4] && cfgb_rd[3]) |-> clk32_out);

endmodule

bind tk_ctl_status tk_ctl_status_chk #(
    .ADDR_W    (ADDR_W),
    .TRIM_ADDR (TRIM_ADDR),
    .CFGB_ADDR (CFGB_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .halt_evt  (halt_evt),
    .lowv_evt  (lowv_evt),
    .chip_en   (chip_en),
    .trim_rd   (trim_rd),
    .cfga_rd   (cfga_rd),
    .cfgb_rd   (cfgb_rd),
    .clk32_out (clk32_out)
);

// File: tb/test_tk_ctl_status.sv
`timescale 1ns/1ps
module test_tk_ctl_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       halt_evt, lowv_evt, chip_en, clk32_in;
    logic [7:0] trim_rd, cfga_rd, cfgb_rd;
    logic       clk32_out, lowv_mon_en, lowv_thr_low, irq_a_en, irq_b_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] mt, ma, mb;

    always #2.5 clk = ~clk;

    tk_ctl_status i_tk_ctl_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .halt_evt(halt_evt), .lowv_evt(lowv_evt), .chip_en(chip_en), .clk32_in(clk32_in),
        .trim_rd(trim_rd), .cfga_rd(cfga_rd), .cfgb_rd(cfgb_rd), .clk32_out(clk32_out),
        .lowv_mon_en(lowv_mon_en), .lowv_thr_low(lowv_thr_low),
        .irq_a_en(irq_a_en), .irq_b_en(irq_b_en)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "trim_rd", trim_rd, mt);
        chk(tag, "cfga_rd", cfga_rd, ma);
        chk(tag, "cfgb_rd", cfgb_rd, mb);
        chk(tag, "lowv_mon_en", {7'd0, lowv_mon_en}, {7'd0, ~mb[6]});
        chk(tag, "lowv_thr_low", {7'd0, lowv_thr_low}, {7'd0, mb[7]});
        chk(tag, "irq_a_en", {7'd0, irq_a_en}, {7'd0, ma[6] | (|ma[2:0])});
        chk(tag, "irq_b_en", {7'd0, irq_b_en}, {7'd0, ma[7]});
        chk(tag, "clk32_out", {7'd0, clk32_out}, {7'd0, (ma[4] & mb[3]) | clk32_in});
    endtask

    // expected next state from the requirements
    task automatic model(input logic we, input logic [3:0] a, input logic [7:0] d,
                         input logic h, input logic lv, input logic ce);
        logic [7:0] nt, na, nb;
        nt = mt; na = ma; nb = mb;
        if (we && a == 4'd7 && !d[7]) nt = {1'b0, d[6:0]};
        if (we && a == 4'd14) na = d;
        if (we && a == 4'd15) begin
            nb = {d[7], mb[6], d[5], mb[4], d[3:0]};
            if (!d[6]) nb[6] = 1'b0;
            if (!d[4]) nb[4] = 1'b0;
        end
        if (lv && !mb[6]) nb[6] = 1'b1;
        if (h && !ce) begin nt = 8'h00; na = 8'h00; nb = 8'h10; end
        mt = nt; ma = na; mb = nb;
    endtask

    // called at a negedge: drive, let one edge pass, sample at next negedge
    task automatic step(input string tag, input logic we, input logic [3:0] a, input logic [7:0] d,
                        input logic h, input logic lv, input logic ce, input logic ck);
        wr_en = we; wr_addr = a; wr_data = d;
        halt_evt = h; lowv_evt = lv; chip_en = ce; clk32_in = ck;
        @(posedge clk);
        model(we, a, d, h, lv, ce);
        @(negedge clk);
        wr_en = 1'b0; halt_evt = 1'b0; lowv_evt = 1'b0;
        check_all(tag);
    endtask

    task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
        step(tag, 1'b1, a, d, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        halt_evt = 1'b0; lowv_evt = 1'b0; chip_en = 1'b1; clk32_in = 1'b0;
        mt = 8'h00; ma = 8'h00; mb = 8'h10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        wr("R2", 4'd14, 8'ha5);
        wr("R2", 4'd15, 8'haf);
        wr("R2", 4'd3, 8'hff);
        wr("R3", 4'd7, 8'h95);
        wr("R3", 4'd7, 8'h55);
        wr("R6", 4'd15, 8'h10);
        step("R5", 1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
        step("R7", 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        wr("R7", 4'd15, 8'h40);
        step("R4", 1'b1, 4'd14, 8'hff, 1'b1, 1'b0, 1'b0, 1'b1);
        wr("R6", 4'd15, 8'h10);
        wr("R6", 4'd15, 8'h00);
        step("R7", 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        step("R8", 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        step("R8", 1'b1, 4'd15, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        wr("R9", 4'd14, 8'h10);
        step("R9", 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        step("R9", 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        wr("R9", 4'd15, 8'h08);
        step("R9", 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        wr("R9", 4'd14, 8'h00);
        step("R9", 1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        wr("R10", 4'd14, 8'h03);
        wr("R10", 4'd14, 8'h40);
        wr("R10", 4'd14, 8'h80);
        wr("R11", 4'd15, 8'ha7);
        step("R4", 1'b1, 4'd15, 8'hff, 1'b1, 1'b1, 1'b0, 1'b0);

        void'($urandom(32'd1234));
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            logic [1:0] sel;
            sel = 2'($urandom_range(3, 0));
            a = (sel == 2'd0) ? 4'd7 : (sel == 2'd1) ? 4'd14 : (sel == 2'd2) ? 4'd15 : 4'($urandom);
            step("RAND", ($urandom_range(3, 0) != 0), a, 8'($urandom),
                 ($urandom_range(19, 0) == 0), ($urandom_range(5, 0) == 0),
                 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule